// File: doc/BRIEF.md
# Associative Address Translation Buffer

This block holds a set of page translations, by default 64, and searches all of them in parallel for each virtual address it is given. Each entry carries a virtual page number, an address space tag, a physical page number, four page sizes selected by flag bits, and a page mask derived from those size bits. A lookup reports a miss, a single hit with the entry index and the translated physical address, or a multiple-hit error. The result is registered and comes out one cycle after the request.

Software maintains the entries through a small register port. It can write the address half or the data half of an entry by index, read either half back by index, or write by content: the written page is searched with the current address space tag, and only the valid and dirty flags of a single matching entry change. A global invalidate clears every valid flag. A replacement counter, as wide as the entry index, advances on every lookup. It wraps to zero at a programmable boundary or at the entry count. Page-table walking and fault vectoring belong to the surrounding logic.

Top module: `tlb_lookup_unit`

## Requirements
- R1: An entry hits only if its valid flag (data bit 8) is set, its virtual page number agrees with bits 31:10 of the lookup address on every bit its page mask keeps, and either its shared flag (data bit 1) is set or its address space tag equals `cur_asid`.
- R2: With `asid_ignore` high the tag and shared test is skipped; only the valid flag and the masked page number decide a hit.
- R3: When more than one entry hits, the result shows `res_multi`=1, `res_hit`=0, index 0 and address 0.
- R4: `res_valid` pulses for one cycle, one cycle after `lkp_req`. A single hit gives `res_index` and `res_paddr` = ((PPN<<10) AND mask) OR (address AND NOT mask). A miss gives `res_hit`=0, index 0 and address 0.
- R5: The size flags {data bit 7, data bit 4} select the page: 00 = 1 KB, 01 = 4 KB, 10 = 64 KB, 11 = 1 MB.
- R6: `repl_count` changes only on a lookup. It then becomes count+1, or 0 when count+1 equals `repl_bound`.
- R7: With `repl_bound` = 0 the counter wraps from 63 to 0.
- R8: A write with `reg_sel`=00 sets the entry's page number from data bits 31:10, its tag from bits 7:0, its valid flag from bit 8 and its dirty flag (data bit 2) from bit 9. A read with `reg_sel`=00 returns the same layout one cycle later.
- R9: A write with `reg_sel`=01 sets the physical page number from bits 28:10 and all nine flags from bits 8:0. A read with `reg_sel`=01 returns {3'b0, PPN, 1'b0, flags} one cycle later.
- R10: A write with `reg_sel`=10 searches bits 31:10 with `cur_asid`. On a single hit it copies bit 8 to the valid flag and bit 9 to the dirty flag of that entry. Otherwise no entry changes.
- R11: `inv_all` clears every valid flag. It also clears the flag that a register write in the same cycle sets.
- R12: After reset every entry is zero and not valid, the counter is 0 and no result is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_asid | input | 8 | Current address space tag |
| asid_ignore | input | 1 | Skip tag and shared test on lookups |
| lkp_req | input | 1 | Lookup strobe |
| lkp_vaddr | input | 32 | Virtual address to translate |
| res_valid | output | 1 | Result pulse, one cycle after the strobe |
| res_hit | output | 1 | Exactly one entry matched |
| res_multi | output | 1 | More than one entry matched |
| res_index | output | 6 | Index of the matching entry |
| res_paddr | output | 32 | Translated physical address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | 00 address half, 01 data half, 10 write by content |
| reg_index | input | 6 | Entry selected for direct access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| inv_all | input | 1 | Clear all valid flags |
| repl_bound | input | 6 | Counter wrap boundary |
| repl_count | output | 6 | Replacement counter |

## Verification
A corrupted page mask or tag shows at the ports on the next lookup of that page. It appears as a wrong physical address, a missing hit or a spurious multiple hit, one cycle after the strobe. A stuck valid flag shows up in the readback word and in the lookups that follow an invalidate or a write by content. A counter that slips by one or misses its wrap differs from the independent count in the bench on the very lookup that goes wrong.

// File: rtl/tlb_pkg.sv
// Shared types and field positions for the translation buffer.
// Assumes 32-bit virtual addresses and a 1 KB minimum page.
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int PG_SH   = 10;
    localparam int VPN_W   = VA_W - PG_SH;
    localparam int PPN_W   = 19;
    localparam int ASID_W  = 8;
    localparam int FLG_W   = 9;
    localparam int F_VALID = 8;
    localparam int F_SZ_HI = 7;
    localparam int F_SZ_LO = 4;
    localparam int F_DIRTY = 2;
    localparam int F_SHARE = 1;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'b00,
        SEL_DATA  = 2'b01,
        SEL_ASSOC = 2'b10,
        SEL_NONE  = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic [FLG_W-1:0]  flags;
        logic [VPN_W-1:0]  mask;
    } tlb_entry_t;

    // Page-number mask kept for a given pair of size flags.
    function automatic logic [VPN_W-1:0] size_mask(input logic [FLG_W-1:0] f);
        case ({f[F_SZ_HI], f[F_SZ_LO]})
            2'b00:   return {VPN_W{1'b1}};
            2'b01:   return {{(VPN_W-2){1'b1}}, 2'b00};
            2'b10:   return {{(VPN_W-6){1'b1}}, 6'b0};
            default: return {{(VPN_W-10){1'b1}}, 10'b0};
        endcase
    endfunction
endpackage

// File: rtl/tlb_match.sv
// Parallel compare of all entries against one search key, with a
// hit encoder. Purely combinational; assumes entries come from a register.
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  tlb_entry_t [N_ENT-1:0] entries,
    input  logic [VPN_W-1:0]       key_vpn,
    input  logic [ASID_W-1:0]      key_asid,
    input  logic                   ign_asid,
    output logic                   hit_one,
    output logic                   hit_multi,
    output logic [IDX_W-1:0]       hit_idx
);
    logic [N_ENT-1:0] hit_vec;

    // One comparator per entry.
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hit_vec[g] = entries[g].flags[F_VALID]
            && (((entries[g].vpn ^ key_vpn) & entries[g].mask) == '0)
            && (ign_asid || entries[g].flags[F_SHARE] || (entries[g].asid == key_asid));
    end

    // Encode the hit vector into none, one with index, or many.
    always_comb begin
        logic found;
        found     = 1'b0;
        hit_multi = 1'b0;
        hit_idx   = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit_vec[i]) begin
                if (found) hit_multi = 1'b1;
                found   = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        hit_one = found && !hit_multi;
    end
endmodule

// File: rtl/tlb_repl_counter.sv
// Replacement counter: steps on each lookup, wraps at a boundary or at
// the entry count. Assumes the boundary is held stable by its owner.
module tlb_repl_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [CNT_W-1:0] bound,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W:0] nxt;
    assign nxt = {1'b0, count} + 1'b1;

    // Advance, wrapping at the boundary or at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (adv) begin
            count <= (nxt[CNT_W] || (nxt[CNT_W-1:0] == bound)) ? '0 : nxt[CNT_W-1:0];
        end
    end

    p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (count == '0) || (count == CNT_W'($past(count) + 1'b1)));
    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(count));
    p_cnt_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (count == '1)) |=> (count == '0));
endmodule

// File: rtl/tlb_entry_store.sv
// Entry storage: direct and by-content writes plus a global invalidate.
// Assumes the by-content match result is computed from the current state.
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [IDX_W-1:0]       wr_index,
    input  logic [VA_W-1:0]        wdata,
    input  logic                   assoc_hit,
    input  logic [IDX_W-1:0]       assoc_idx,
    input  logic                   inv_all,
    output tlb_entry_t [N_ENT-1:0] entries
);
    logic [N_ENT-1:0] valid_vec;
    for (genvar g = 0; g < N_ENT; g++) begin : g_vld
        assign valid_vec[g] = entries[g].flags[F_VALID];
    end

    // Apply the register write, then let the invalidate override valid flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entries <= '0;
        end else begin
            if (wr_en) begin
                case (reg_sel_e'(wr_sel))
                    SEL_ADDR: begin
                        entries[wr_index].vpn            <= wdata[VA_W-1:PG_SH];
                        entries[wr_index].asid           <= wdata[ASID_W-1:0];
                        entries[wr_index].flags[F_VALID] <= wdata[8];
                        entries[wr_index].flags[F_DIRTY] <= wdata[9];
                    end
                    SEL_DATA: begin
                        entries[wr_index].ppn   <= wdata[PG_SH+PPN_W-1:PG_SH];
                        entries[wr_index].flags <= wdata[FLG_W-1:0];
                        entries[wr_index].mask  <= size_mask(wdata[FLG_W-1:0]);
                    end
                    SEL_ASSOC: begin
                        if (assoc_hit) begin
                            entries[assoc_idx].flags[F_VALID] <= wdata[8];
                            entries[assoc_idx].flags[F_DIRTY] <= wdata[9];
                        end
                    end
                    default: ;
                endcase
            end
            if (inv_all) begin
                for (int i = 0; i < N_ENT; i++) entries[i].flags[F_VALID] <= 1'b0;
            end
        end
    end

    p_inv_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_vec == '0));
    p_assoc_miss_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 2'b10) && !assoc_hit && !inv_all) |=> $stable(valid_vec));
endmodule

// File: rtl/tlb_lookup_unit.sv
// Top of the translation buffer: registered lookup, register access,
// by-content write and replacement counter. Assumes software never
// issues a register write that must be seen by a lookup in the same cycle.
module tlb_lookup_unit
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cur_asid,
    input  logic              asid_ignore,
    input  logic              lkp_req,
    input  logic [31:0]       lkp_vaddr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_multi,
    output logic [IDX_W-1:0]  res_index,
    output logic [31:0]       res_paddr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [IDX_W-1:0]  reg_index,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              inv_all,
    input  logic [IDX_W-1:0]  repl_bound,
    output logic [IDX_W-1:0]  repl_count
);
    tlb_entry_t [N_ENT-1:0] entries;
    logic                   l_one, l_multi, a_one, a_multi;
    logic [IDX_W-1:0]       l_idx, a_idx;
    logic [VPN_W-1:0]       pa_vpn;
    tlb_entry_t             sel_ent, rd_ent;

    tlb_entry_store #(.N_ENT(N_ENT)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel),
        .wr_index(reg_index), .wdata(reg_wdata),
        .assoc_hit(a_one), .assoc_idx(a_idx), .inv_all(inv_all),
        .entries(entries)
    );

    tlb_match #(.N_ENT(N_ENT)) lkp_match_i (
        .entries(entries), .key_vpn(lkp_vaddr[VA_W-1:PG_SH]), .key_asid(cur_asid),
        .ign_asid(asid_ignore), .hit_one(l_one), .hit_multi(l_multi), .hit_idx(l_idx)
    );

    tlb_match #(.N_ENT(N_ENT)) wr_match_i (
        .entries(entries), .key_vpn(reg_wdata[VA_W-1:PG_SH]), .key_asid(cur_asid),
        .ign_asid(1'b0), .hit_one(a_one), .hit_multi(a_multi), .hit_idx(a_idx)
    );

    tlb_repl_counter #(.CNT_W(IDX_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .adv(lkp_req), .bound(repl_bound), .count(repl_count)
    );

    // Translate through the winning entry.
    assign sel_ent = entries[l_idx];
    assign pa_vpn  = ({{(VPN_W-PPN_W){1'b0}}, sel_ent.ppn} & sel_ent.mask)
                   | (lkp_vaddr[VA_W-1:PG_SH] & ~sel_ent.mask);
    assign rd_ent  = entries[reg_index];

    // Register the lookup outcome one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_multi <= 1'b0;
            res_index <= '0;
            res_paddr <= '0;
        end else begin
            res_valid <= lkp_req;
            if (lkp_req) begin
                res_hit   <= l_one;
                res_multi <= l_multi;
                res_index <= l_one ? l_idx : '0;
                res_paddr <= l_one ? {pa_vpn, lkp_vaddr[PG_SH-1:0]} : '0;
            end
        end
    end

    // Register the read-back word of the selected entry half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= reg_sel[0]
                ? {3'b0, rd_ent.ppn, 1'b0, rd_ent.flags}
                : {rd_ent.vpn, rd_ent.flags[F_DIRTY], rd_ent.flags[F_VALID], rd_ent.asid};
        end
    end

    p_res_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req |=> res_valid);
    p_res_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_req |=> !res_valid);
    p_hit_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_hit && res_multi));
    p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> ((res_paddr == '0) && (res_index == '0)));
    p_multi_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && l_multi) |=> res_multi);
endmodule

// File: tb/tlb_lookup_unit_tb_top.sv
// Scoreboard bench: lookups push expected results; a monitor pops and compares.
module tlb_lookup_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic        asid_ignore = 1'b0;
    logic        lkp_req = 1'b0;
    logic [31:0] lkp_vaddr = '0;
    logic        res_valid, res_hit, res_multi;
    logic [5:0]  res_index;
    logic [31:0] res_paddr;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [5:0]  reg_index = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        inv_all = 1'b0;
    logic [5:0]  repl_bound = '0;
    logic [5:0]  repl_count;

    int checks = 0;
    int failures = 0;
    int exp_cnt = 0;

    typedef struct packed {
        logic        hit;
        logic        multi;
        logic [5:0]  idx;
        logic [31:0] pa;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    tlb_lookup_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .asid_ignore(asid_ignore),
        .lkp_req(lkp_req), .lkp_vaddr(lkp_vaddr), .res_valid(res_valid),
        .res_hit(res_hit), .res_multi(res_multi), .res_index(res_index),
        .res_paddr(res_paddr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_index(reg_index), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .inv_all(inv_all), .repl_bound(repl_bound), .repl_count(repl_count)
    );

    task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each registered result with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected result", 40'(res_hit), 40'h0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({res_hit, res_multi, res_index, res_paddr} == e, t,
                      {res_hit, res_multi, res_index, res_paddr}, e);
            end
        end
    end

    task automatic wr_reg(input logic [1:0] sel, input logic [5:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_index = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] sel, input logic [5:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = sel; reg_index = idx;
        @(negedge clk);
        reg_rd = 1'b0;
        check(reg_rdata == exp, tag, 40'(reg_rdata), 40'(exp));
    endtask

    // Driver: issue one lookup, queue its expected result, check the counter (R6, R7).
    task automatic do_lookup(input logic [31:0] va, input logic [7:0] asid, input logic ign,
                             input logic hit, input logic multi, input logic [5:0] idx,
                             input logic [31:0] pa, input string tag);
        int nxt;
        @(negedge clk);
        cur_asid = asid; asid_ignore = ign; lkp_req = 1'b1; lkp_vaddr = va;
        exp_q.push_back({hit, multi, idx, pa});
        tag_q.push_back(tag);
        nxt = exp_cnt + 1;
        exp_cnt = ((nxt == int'(repl_bound)) || (nxt == 64)) ? 0 : nxt;
        @(negedge clk);
        lkp_req = 1'b0;
        check(int'(repl_count) == exp_cnt, "R6 R7 replacement counter", 40'(repl_count), 40'(exp_cnt));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(res_valid == 1'b0, "R12 no result after reset", 40'(res_valid), 40'h0);
        check(repl_count == 6'd0, "R12 counter zero", 40'(repl_count), 40'h0);
        rd_check(2'b00, 6'd0, 32'h0, "R12 entry cleared");
        do_lookup(32'h0000_0000, 8'h00, 1'b0, 1'b0, 1'b0, 6'd0, 32'h0, "R12 empty buffer misses");

        // Entry 3: 4 KB page, tag 5
        wr_reg(2'b01, 6'd3, 32'h002A_F114);
        wr_reg(2'b00, 6'd3, 32'h4000_1105);
        do_lookup(32'h4000_1234, 8'h05, 1'b0, 1'b1, 1'b0, 6'd3, 32'h002A_F234, "R1 R4 R5 4KB hit");
        do_lookup(32'h4000_1234, 8'h06, 1'b0, 1'b0, 1'b0, 6'd0, 32'h0, "R1 tag mismatch misses");
        wr_reg(2'b01, 6'd3, 32'h002A_F116);
        do_lookup(32'h4000_1234, 8'h06, 1'b0, 1'b1, 1'b0, 6'd3, 32'h002A_F234, "R1 shared entry hits");
        wr_reg(2'b01, 6'd3, 32'h002A_F114);
        do_lookup(32'h4000_1234, 8'h06, 1'b1, 1'b1, 1'b0, 6'd3, 32'h002A_F234, "R2 ignore mode hits");
        do_lookup(32'h4000_1234, 8'h06, 1'b0, 1'b0, 1'b0, 6'd0, 32'h0, "R2 normal mode misses");
        rd_check(2'b01, 6'd3, 32'h002A_F114, "R9 data readback");
        rd_check(2'b00, 6'd3, 32'h4000_1305, "R8 address readback with dirty");

        // Entry 7: 1 MB shared page overlapping entry 3
        wr_reg(2'b01, 6'd7, 32'h0040_0192);
        wr_reg(2'b00, 6'd7, 32'h4000_0109);
        do_lookup(32'h4000_1234, 8'h05, 1'b0, 1'b0, 1'b1, 6'd0, 32'h0, "R3 multiple hit");
        do_lookup(32'h400F_0000, 8'h05, 1'b0, 1'b1, 1'b0, 6'd7, 32'h004F_0000, "R5 1MB hit");

        // Entry 10: 64 KB page
        wr_reg(2'b01, 6'd10, 32'h0004_0180);
        wr_reg(2'b00, 6'd10, 32'h0023_0105);
        do_lookup(32'h0023_ABCD, 8'h05, 1'b0, 1'b1, 1'b0, 6'd10, 32'h0004_ABCD, "R5 64KB hit");
        do_lookup(32'h0024_0000, 8'h05, 1'b0, 1'b0, 1'b0, 6'd0, 32'h0, "R5 64KB boundary miss");

        // Entry 12: 1 KB page
        wr_reg(2'b01, 6'd12, 32'h0000_8100);
        wr_reg(2'b00, 6'd12, 32'h0080_0105);
        do_lookup(32'h0080_03FF, 8'h05, 1'b0, 1'b1, 1'b0, 6'd12, 32'h0000_83FF, "R5 1KB hit");
        do_lookup(32'h0080_0400, 8'h05, 1'b0, 1'b0, 1'b0, 6'd0, 32'h0, "R5 1KB boundary miss");

        // R10: write by content
        wr_reg(2'b10, 6'd0, 32'h0080_0000);
        do_lookup(32'h0080_0010, 8'h05, 1'b0, 1'b0, 1'b0, 6'd0, 32'h0, "R10 content write cleared valid");
        rd_check(2'b00, 6'd12, 32'h0080_0005, "R10 address half after clear");
        rd_check(2'b01, 6'd12, 32'h0000_8000, "R10 data half after clear");
        wr_reg(2'b10, 6'd0, 32'h0080_0300);
        rd_check(2'b00, 6'd12, 32'h0080_0005, "R10 no match leaves entry");
        wr_reg(2'b10, 6'd0, 32'h0023_0300);
        rd_check(2'b00, 6'd10, 32'h0023_0305, "R10 match sets valid and dirty");

        // R8: direct address write with dirty
        wr_reg(2'b00, 6'd12, 32'h0080_0305);
        rd_check(2'b00, 6'd12, 32'h0080_0305, "R8 direct address write");
        rd_check(2'b01, 6'd12, 32'h0000_8104, "R8 R9 dirty and valid in data half");

        // R6 R7: counter wrap at 64 then at a boundary
        for (int i = 0; i < 70; i++)
            do_lookup(32'hFFFF_0000, 8'h33, 1'b0, 1'b0, 1'b0, 6'd0, 32'h0, "R7 filler miss");
        repl_bound = 6'd5;
        for (int i = 0; i < 70; i++)
            do_lookup(32'hFFFF_0000, 8'h33, 1'b0, 1'b0, 1'b0, 6'd0, 32'h0, "R6 filler miss");

        // R11: invalidate together with a data write
        @(negedge clk);
        inv_all = 1'b1; reg_wr = 1'b1; reg_sel = 2'b01; reg_index = 6'd20; reg_wdata = 32'h0000_1100;
        @(negedge clk);
        inv_all = 1'b0; reg_wr = 1'b0;
        do_lookup(32'h4000_1234, 8'h05, 1'b0, 1'b0, 1'b0, 6'd0, 32'h0, "R11 4KB entry invalid");
        do_lookup(32'h400F_0000, 8'h05, 1'b0, 1'b0, 1'b0, 6'd0, 32'h0, "R11 1MB entry invalid");
        rd_check(2'b01, 6'd20, 32'h0000_1000, "R11 same-cycle write loses valid");
        rd_check(2'b00, 6'd3, 32'h4000_1205, "R11 valid cleared dirty kept");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 all results seen", 40'(exp_q.size()), 40'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule